// File: doc/BRIEF.md
# Transmit Cell-Marker Inserter

This block sits between a transmit FIFO write port and an 8B/10B encoder. Each entry written into its internal 16-deep FIFO carries a data byte and three tag bits: start-of-cell, command select and address select. The read side runs one character slot per clock. An entry without the start-of-cell tag goes to the encoder as a plain data byte. An entry with that tag takes two slots. The first slot carries a special marker character chosen from the tag bits. The second slot carries the entry's own data byte.

The marker is picked when the entry reaches the FIFO head, not when it is written. The writer can therefore load entries in any cycle pattern. When the FIFO is empty, or a halt input is high at a character boundary, the block sends comma fill characters and leaves the FIFO untouched.

Top module: `cell_marker_tx`

## Requirements
- R1: An entry whose start-of-cell tag is 0 is sent as its data byte with `tx_k` = 0, in write order. Its command and address select bits are ignored.
- R2: An entry with start-of-cell = 1 and command select = 0 is preceded by 0xF7 with `tx_k` = 1 (K23.7). This holds whatever the address select bit is.
- R3: An entry with start-of-cell = 1, command select = 1 and address select = 0 is preceded by 0xFB with `tx_k` = 1 (K27.7).
- R4: An entry with start-of-cell, command select and address select all 1 is preceded by 0xFD with `tx_k` = 1 (K29.7).
- R5: The data slot of a tagged entry comes in the clock directly after its marker, even if `halt` is high in that slot. The entry is removed from the FIFO only in its data slot.
- R6: At a character boundary where the FIFO is empty or `halt` is 1, the block sends 0xBC with `tx_k` = 1 (K28.5) and removes no entry.
- R7: `fifo_full` is 1 exactly when 16 entries are held. A write made while `fifo_full` is 1 is dropped.
- R8: `fifo_empty` is 1 exactly when no entry is held. An entry written at one clock edge is chosen for output at the next edge at the earliest.
- R9: After reset, `tx_byte` = 0xBC, `tx_k` = 1, `fifo_empty` = 1 and `fifo_full` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one character slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one entry into the FIFO |
| wr_data | input | 8 | Data byte of the entry |
| wr_soc | input | 1 | Start-of-cell tag |
| wr_cmd | input | 1 | Command select tag |
| wr_adr | input | 1 | Address select tag |
| halt | input | 1 | Hold reads at the next character boundary |
| fifo_full | output | 1 | FIFO holds 16 entries |
| fifo_empty | output | 1 | FIFO holds no entries |
| tx_byte | output | 8 | Character byte to the encoder |
| tx_k | output | 1 | Byte is a special character |

## Verification
Streams of untagged bytes with random command and address bits separate plain passthrough from marker insertion. One tagged entry of each tag combination, including start-of-cell with only the address bit set, shows which marker is selected. Raising halt exactly in a marker slot shows whether the data slot is held back. Filling to 16 entries behind a halt and then writing more shows the full flag and dropped writes. A long random mix of writes, tags and halts, compared cycle by cycle with a queue model, covers concurrent push and pop and the empty-to-nonempty edge.

// File: rtl/cell_marker_tx.sv
module cell_marker_tx #(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_soc,
  input  logic       wr_cmd,
  input  logic       wr_adr,
  input  logic       halt,
  output logic       fifo_full,
  output logic       fifo_empty,
  output logic [7:0] tx_byte,
  output logic       tx_k
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [7:0] K_FILL = 8'hBC, K_CELL = 8'hF7, K_CMD = 8'hFB, K_ADR = 8'hFD;

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pend;
  logic [10:0]   head;
  logic [7:0]    nxt_byte;
  logic          nxt_k;

  assign fifo_full  = (cnt == FULL_CNT);
  assign fifo_empty = (cnt == '0);
  assign head       = mem[rp];

  wire push = wr_en & ~fifo_full;
  wire go   = ~pend & ~fifo_empty & ~halt;
  wire mark = go & head[8];
  wire pop  = pend | (go & ~head[8]);

  always_comb begin
    if (pend || (go && !head[8])) begin
      nxt_byte = head[7:0];
      nxt_k    = 1'b0;
    end else if (mark) begin
      nxt_byte = head[9] ? (head[10] ? K_ADR : K_CMD) : K_CELL;
      nxt_k    = 1'b1;
    end else begin
      nxt_byte = K_FILL;
      nxt_k    = 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= {wr_adr, wr_cmd, wr_soc, wr_data};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      pend    <= 1'b0;
      tx_byte <= K_FILL;
      tx_k    <= 1'b1;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      cnt     <= cnt + (AW+1)'(push) - (AW+1)'(pop);
      pend    <= mark;
      tx_byte <= nxt_byte;
      tx_k    <= nxt_k;
    end
  end

  // R5
  marker_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_k && (tx_byte == K_CELL || tx_byte == K_CMD || tx_byte == K_ADR)) |=> !tx_k);

  // R6
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_empty && !wr_en) |=> (fifo_empty && (!$past(pend) -> (tx_k && tx_byte == K_FILL))));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !pend && halt) |=> fifo_full);

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R9
  reset_fill_chk: assert property (@(posedge clk)
    !rst_n |=> (tx_k && tx_byte == K_FILL && fifo_empty));
endmodule

// File: tb/tb_cell_marker_tx.sv
module tb_cell_marker_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_soc = 1'b0, wr_cmd = 1'b0, wr_adr = 1'b0, halt = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic fifo_full, fifo_empty, tx_k;
  logic [7:0] tx_byte;

  int checks = 0, failures = 0;
  logic [10:0] q[$];
  bit pend = 0;
  logic [7:0] exp_byte;
  logic exp_k;
  string exp_req;
  bit done = 0;

  always #2.5 clk = ~clk;

  cell_marker_tx dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_soc(wr_soc), .wr_cmd(wr_cmd), .wr_adr(wr_adr), .halt(halt),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .tx_byte(tx_byte), .tx_k(tx_k));

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic s, input logic c,
                      input logic a, input logic h);
    bit accept;
    chk("R7", {8'h0, fifo_full}, {8'h0, q.size() == 16});
    chk("R8", {8'h0, fifo_empty}, {8'h0, q.size() == 0});
    wr_en = w; wr_data = d; wr_soc = s; wr_cmd = c; wr_adr = a; halt = h;
    accept = w && (q.size() < 16);
    if (pend) begin
      exp_byte = q[0][7:0]; exp_k = 0; exp_req = "R5"; void'(q.pop_front()); pend = 0;
    end else if (q.size() == 0 || h) begin
      exp_byte = 8'hBC; exp_k = 1; exp_req = "R6";
    end else if (q[0][8]) begin
      exp_k = 1; pend = 1;
      if (!q[0][9]) begin exp_byte = 8'hF7; exp_req = "R2"; end
      else if (!q[0][10]) begin exp_byte = 8'hFB; exp_req = "R3"; end
      else begin exp_byte = 8'hFD; exp_req = "R4"; end
    end else begin
      exp_byte = q[0][7:0]; exp_k = 0; exp_req = "R1"; void'(q.pop_front());
    end
    if (accept) q.push_back({a, c, s, d});
    @(negedge clk);
    chk(exp_req, {tx_byte, tx_k}, {exp_byte, exp_k});
  endtask

  task automatic idle(input int n, input logic h);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 0, 0, h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9
    chk("R9", {tx_byte, tx_k}, {8'hBC, 1'b1});
    chk("R9", {7'h0, fifo_empty, fifo_full}, {7'h0, 1'b1, 1'b0});
    rst_n = 1'b1;
    idle(3, 0);
    // R1: plain bytes with stray select bits
    for (int i = 0; i < 6; i++) step(1, 8'h10 + 8'(i), 0, i[0], i[1], 0);
    idle(8, 0);
    // R2, R3, R4 and start-of-cell with only the address bit
    step(1, 8'hA1, 1, 0, 0, 0);
    step(1, 8'hA2, 1, 1, 0, 0);
    step(1, 8'hA3, 1, 1, 1, 0);
    step(1, 8'hA4, 1, 0, 1, 0);
    step(1, 8'hA5, 0, 0, 0, 0);
    idle(12, 0);
    // R5: halt raised in the data slot of a tagged entry
    step(1, 8'h5A, 1, 1, 0, 0);
    step(0, 8'h00, 0, 0, 0, 0);
    step(0, 8'h00, 0, 0, 0, 1);
    idle(3, 0);
    // R7: fill behind halt, then overflow
    for (int i = 0; i < 20; i++) step(1, 8'hC0 + 8'(i), i[2], i[0], i[1], 1);
    idle(4, 1);
    idle(40, 0);
    // mixed random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 99) < 55), 8'($urandom), ($urandom_range(0, 3) == 0),
           1'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0));
    idle(40, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule